// File: doc/BRIEF.md
# AC-link Controller Frame Engine

This block is the controller end of a five-wire serial audio codec link. The codec supplies the bit clock. The engine divides that clock into 256-bit frames and marks the start of each frame with a SYNC pulse. Every frame has a 16-bit tag word followed by twelve 20-bit slots, and all fields go out most significant bit first.

On the outgoing serial line the engine sends a tag word. It also sends a register command made of a read/write flag, a 7-bit register address and 16 bits of write data, plus a left and a right playback sample. From the incoming line it recovers the codec's tag word, the slot-request field, register read replies and left/right record samples.

The host side has two request ports, one for register commands and one for playback samples. Each port has a single holding register that is emptied once per frame. Record samples and read replies come back as one-cycle pulses with their data. A register read is only completed when the codec returns a reply whose address matches the outstanding read.

Top module: `aclink_engine`

## Requirements
- R1: `sync` rises at the first bit of every frame, stays high for exactly 16 bit clocks (the tag word), and rises again exactly 256 bit clocks later.
- R2: Outgoing tag word layout: bit 15 is set when any slot of the frame carries data. Bit 14 flags the command address slot and bit 13 the command data slot. Bits 12 and 11 flag the left and right playback slots. Bits 1:0 carry the command's 2-bit codec ID. All other tag bits are zero.
- R3: Outgoing slot 1 holds 1 for a read (0 for a write) in bit 19 and the register address in bits 18:12, with bits 11:0 zero. For a write, slot 2 holds the write data in bits 19:4, with bits 3:0 zero.
- R4: An accepted command goes out whole in the next frame to start, with address and data together. A read sets only tag bit 14 and leaves slot 2 zero. `cmd_ready` stays low from acceptance until the command is sent, and stays low for as long as a read is outstanding.
- R5: An accepted playback pair goes out once, in slots 3 (left) and 4 (right) of the next frame to start. A frame with no sample has tag bits 12 and 11 clear and slots 3 and 4 zero. `play_ready` drops for the cycles between acceptance and the frame load.
- R6: Slots 5 to 12, and every slot without data, are driven as zero.
- R7: The incoming line is sampled on the falling bit-clock edge. After an incoming frame whose tag bits 15, 12 and 11 are all set, `rec_valid` pulses for one cycle with slot 3 on `rec_left` and slot 4 on `rec_right`. Otherwise no record sample is reported.
- R8: After every incoming frame, `rx_tag` shows its tag word and `rx_slot_req` shows bits 11:2 of its slot 1, whatever its tag bits are.
- R9: `rd_valid` pulses once, with bits 19:4 of incoming slot 2 on `rd_data`, only for an incoming frame that has tag bits 15, 14 and 13 set, while a read is outstanding, and whose slot 1 bits 18:12 equal the outstanding read address. That pulse ends the outstanding read.
- R10: While reset is asserted, `sync`, `sdata_out`, `rd_valid` and `rec_valid` are low, and `cmd_ready` and `play_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | output | 1 | Frame marker, high during the tag word |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| cmd_valid | input | 1 | Register command offered |
| cmd_ready | output | 1 | Command holding register can accept |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_codec_id | input | 2 | Target codec ID |
| play_valid | input | 1 | Playback pair offered |
| play_ready | output | 1 | Playback holding register can accept |
| play_left | input | 20 | Left playback sample |
| play_right | input | 20 | Right playback sample |
| rec_valid | output | 1 | Record pair pulse |
| rec_left | output | 20 | Left record sample |
| rec_right | output | 20 | Right record sample |
| rd_valid | output | 1 | Read reply pulse |
| rd_data | output | 16 | Read reply data |
| rx_tag | output | 16 | Tag word of the last incoming frame |
| rx_slot_req | output | 10 | Slot-request field of the last incoming frame |

## Verification
The assertions assume that `bit_clk` runs without gaps. They also assume the host changes its request signals only away from the rising edge and does not offer a command while `cmd_ready` is low. The frame-shape checks further assume that nothing but the engine's own counter moves `sync`. The stimulus changes inputs only on falling edges and waits for ready before each handshake. The codec model in the bench launches each incoming bit just after the rising edge, aligned to the observed `sync` rise, so that the falling-edge sample falls inside the bit.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_W    = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W      = $clog2(FRAME_W);
  localparam int REG_AW     = 7;
  localparam int REG_DW     = 16;
  localparam int PCM_W      = SLOT_W;
  localparam int ID_W       = 2;
  localparam int REQ_W      = 10;
  localparam int REQ_LSB    = 2;
  localparam int TX_SLOTS   = 4;
  localparam int RX_KEEP    = TAG_W + SLOT_W * TX_SLOTS;
  localparam int IDLE_START = RX_KEEP;
  localparam int CMD_RSV_W  = SLOT_W - 1 - REG_AW;
  localparam int DATA_PAD_W = SLOT_W - REG_DW;

  localparam int TAG_READY  = 15;
  localparam int TAG_CMD_A  = 14;
  localparam int TAG_CMD_D  = 13;
  localparam int TAG_PCM_L  = 12;
  localparam int TAG_PCM_R  = 11;

  typedef struct packed {
    logic              rd;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
    logic [ID_W-1:0]   id;
  } cmd_t;

  typedef struct packed {
    logic [PCM_W-1:0] left;
    logic [PCM_W-1:0] right;
  } pcm_t;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             frame_end,
  output logic             sync
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             sync_q, sync_d;

  always_comb begin
    frame_end = (pos_q == POS_W'(FRAME_W - 1));
    pos_d     = frame_end ? '0 : pos_q + 1'b1;
    sync_d    = (pos_d < POS_W'(TAG_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_W'(FRAME_W - 1);
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end

  assign pos  = pos_q;
  assign sync = sync_q;
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              cmd_valid,
  input  cmd_t              cmd_in,
  output logic              cmd_ready,
  input  logic              play_valid,
  input  pcm_t              play_in,
  output logic              play_ready,
  input  logic              rd_done,
  output logic              rd_pend,
  output logic [REG_AW-1:0] rd_pend_addr,
  output logic              sdata_out
);
  cmd_t               cmd_q;
  pcm_t               play_q;
  logic               cmd_full, cmd_full_d;
  logic               play_full, play_full_d;
  logic               pend_q, pend_d;
  logic [REG_AW-1:0]  pend_addr_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sdo_q, sdo_d;
  logic               cmd_acc, play_acc, rd_load;
  logic [TAG_W-1:0]   tag;
  logic [SLOT_W-1:0]  tx_slot [TX_SLOTS];
  logic [FRAME_W-1:0] frame;

  always_comb begin
    tag            = '0;
    tag[TAG_READY] = cmd_full | play_full;
    tag[TAG_CMD_A] = cmd_full;
    tag[TAG_CMD_D] = cmd_full & ~cmd_q.rd;
    tag[TAG_PCM_L] = play_full;
    tag[TAG_PCM_R] = play_full;
    tag[ID_W-1:0]  = cmd_full ? cmd_q.id : '0;
    tx_slot[0] = cmd_full ? {cmd_q.rd, cmd_q.addr, {CMD_RSV_W{1'b0}}} : '0;
    tx_slot[1] = (cmd_full && !cmd_q.rd) ? {cmd_q.data, {DATA_PAD_W{1'b0}}} : '0;
    tx_slot[2] = play_full ? play_q.left  : '0;
    tx_slot[3] = play_full ? play_q.right : '0;
  end

  assign frame[FRAME_W-1 -: TAG_W] = tag;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int MSB = FRAME_W - 1 - TAG_W - SLOT_W * g;
    if (g < TX_SLOTS) begin : g_used
      assign frame[MSB -: SLOT_W] = tx_slot[g];
    end else begin : g_idle
      assign frame[MSB -: SLOT_W] = '0;
    end
  end

  always_comb begin
    cmd_ready   = ~cmd_full & ~pend_q;
    play_ready  = ~play_full;
    cmd_acc     = cmd_valid & cmd_ready;
    play_acc    = play_valid & play_ready;
    rd_load     = frame_end & cmd_full & cmd_q.rd;
    cmd_full_d  = cmd_acc  ? 1'b1 : (frame_end ? 1'b0 : cmd_full);
    play_full_d = play_acc ? 1'b1 : (frame_end ? 1'b0 : play_full);
    if (rd_load)      pend_d = 1'b1;
    else if (rd_done) pend_d = 1'b0;
    else              pend_d = pend_q;
    if (frame_end) begin
      sdo_d = frame[FRAME_W-1];
      sr_d  = {frame[FRAME_W-2:0], 1'b0};
    end else begin
      sdo_d = sr_q[FRAME_W-1];
      sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_full    <= 1'b0;
      play_full   <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      cmd_q       <= '0;
      play_q      <= '0;
      sr_q        <= '0;
      sdo_q       <= 1'b0;
    end else begin
      cmd_full  <= cmd_full_d;
      play_full <= play_full_d;
      pend_q    <= pend_d;
      sr_q      <= sr_d;
      sdo_q     <= sdo_d;
      if (cmd_acc)  cmd_q       <= cmd_in;
      if (play_acc) play_q      <= play_in;
      if (rd_load)  pend_addr_q <= cmd_q.addr;
    end
  end

  assign rd_pend      = pend_q;
  assign rd_pend_addr = pend_addr_q;
  assign sdata_out    = sdo_q;
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_in,
  input  logic [POS_W-1:0]  pos,
  input  logic              frame_end,
  input  logic              rd_pend,
  input  logic [REG_AW-1:0] rd_pend_addr,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [REQ_W-1:0]  rx_slot_req,
  output logic              rec_valid,
  output logic [PCM_W-1:0]  rec_left,
  output logic [PCM_W-1:0]  rec_right,
  output logic              rd_valid,
  output logic [REG_DW-1:0] rd_data
);
  localparam int S1_LSB = RX_KEEP - TAG_W - SLOT_W;
  localparam int S2_LSB = S1_LSB - SLOT_W;
  localparam int S3_LSB = S2_LSB - SLOT_W;
  localparam int S4_LSB = S3_LSB - SLOT_W;

  logic               samp_q;
  logic [RX_KEEP-1:0] sr_q;
  logic               cap_en;
  logic [TAG_W-1:0]   tag_w;
  logic               rec_hit, rd_hit;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= sdata_in;
  end

  always_comb begin
    cap_en  = (pos < POS_W'(RX_KEEP));
    tag_w   = sr_q[RX_KEEP-1 -: TAG_W];
    rec_hit = tag_w[TAG_READY] & tag_w[TAG_PCM_L] & tag_w[TAG_PCM_R];
    rd_hit  = tag_w[TAG_READY] & tag_w[TAG_CMD_A] & tag_w[TAG_CMD_D] & rd_pend &
              (sr_q[S1_LSB + SLOT_W - 1 - REG_AW +: REG_AW] == rd_pend_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q        <= '0;
      rx_tag      <= '0;
      rx_slot_req <= '0;
      rec_valid   <= 1'b0;
      rec_left    <= '0;
      rec_right   <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      if (cap_en) sr_q <= {sr_q[RX_KEEP-2:0], samp_q};
      rec_valid <= frame_end & rec_hit;
      rd_valid  <= frame_end & rd_hit;
      if (frame_end) begin
        rx_tag      <= tag_w;
        rx_slot_req <= sr_q[S1_LSB + REQ_LSB +: REQ_W];
      end
      if (frame_end && rec_hit) begin
        rec_left  <= sr_q[S3_LSB +: PCM_W];
        rec_right <= sr_q[S4_LSB +: PCM_W];
      end
      if (frame_end && rd_hit) rd_data <= sr_q[S2_LSB + DATA_PAD_W +: REG_DW];
    end
  end
endmodule

// File: rtl/aclink_engine.sv
module aclink_engine
  import aclink_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  output logic              sync,
  output logic              sdata_out,
  input  logic              sdata_in,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [REG_AW-1:0] cmd_addr,
  input  logic [REG_DW-1:0] cmd_wdata,
  input  logic [ID_W-1:0]   cmd_codec_id,
  input  logic              play_valid,
  output logic              play_ready,
  input  logic [PCM_W-1:0]  play_left,
  input  logic [PCM_W-1:0]  play_right,
  output logic              rec_valid,
  output logic [PCM_W-1:0]  rec_left,
  output logic [PCM_W-1:0]  rec_right,
  output logic              rd_valid,
  output logic [REG_DW-1:0] rd_data,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [REQ_W-1:0]  rx_slot_req
);
  logic              rst_meta_n, rst_sync_n;
  logic [POS_W-1:0]  pos;
  logic              frame_end;
  logic              rd_pend;
  logic [REG_AW-1:0] rd_pend_addr;
  cmd_t              cmd_in;
  pcm_t              play_in;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    cmd_in.rd     = ~cmd_write;
    cmd_in.addr   = cmd_addr;
    cmd_in.data   = cmd_wdata;
    cmd_in.id     = cmd_codec_id;
    play_in.left  = play_left;
    play_in.right = play_right;
  end

  aclink_frame_timer u_timer (
    .clk       (bit_clk),
    .rst_n     (rst_sync_n),
    .pos       (pos),
    .frame_end (frame_end),
    .sync      (sync)
  );

  aclink_tx u_tx (
    .clk          (bit_clk),
    .rst_n        (rst_sync_n),
    .frame_end    (frame_end),
    .cmd_valid    (cmd_valid),
    .cmd_in       (cmd_in),
    .cmd_ready    (cmd_ready),
    .play_valid   (play_valid),
    .play_in      (play_in),
    .play_ready   (play_ready),
    .rd_done      (rd_valid),
    .rd_pend      (rd_pend),
    .rd_pend_addr (rd_pend_addr),
    .sdata_out    (sdata_out)
  );

  aclink_rx u_rx (
    .clk          (bit_clk),
    .rst_n        (rst_sync_n),
    .sdata_in     (sdata_in),
    .pos          (pos),
    .frame_end    (frame_end),
    .rd_pend      (rd_pend),
    .rd_pend_addr (rd_pend_addr),
    .rx_tag       (rx_tag),
    .rx_slot_req  (rx_slot_req),
    .rec_valid    (rec_valid),
    .rec_left     (rec_left),
    .rec_right    (rec_right),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
  );
endmodule

// File: rtl/aclink_engine_chk.sv
module aclink_engine_chk
  import aclink_pkg::*;
(
  input logic bit_clk,
  input logic rst_n,
  input logic sync,
  input logic sdata_out,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic play_valid,
  input logic play_ready,
  input logic rd_valid,
  input logic rec_valid
);
  logic             prev_sync, seen;
  logic [POS_W-1:0] pos_r, cur;

  always_comb cur = (sync && !prev_sync) ? '0 : pos_r + 1'b1;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sync <= 1'b0;
      seen      <= 1'b0;
      pos_r     <= '0;
    end else begin
      prev_sync <= sync;
      pos_r     <= cur;
      if (sync && !prev_sync) seen <= 1'b1;
    end
  end

  assert_sync_shape_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    seen |-> (sync == (cur < POS_W'(TAG_W))));

  assert_frame_period_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (seen && sync && !prev_sync) |-> (pos_r == POS_W'(FRAME_W - 1)));

  assert_idle_slots_zero_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (seen && cur >= POS_W'(IDLE_START)) |-> !sdata_out);

  assert_cmd_hold_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_play_hold_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (play_valid && play_ready) |=> !play_ready);

  assert_rec_pulse_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  assert_rd_pulse_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_rd_blocks_cmd_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);
endmodule

bind aclink_engine aclink_engine_chk u_chk (
  .bit_clk    (bit_clk),
  .rst_n      (rst_sync_n),
  .sync       (sync),
  .sdata_out  (sdata_out),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .play_valid (play_valid),
  .play_ready (play_ready),
  .rd_valid   (rd_valid),
  .rec_valid  (rec_valid)
);

// File: tb/aclink_engine_tb.sv
`timescale 1ns/1ps
module aclink_engine_tb;
  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync, sdata_out, sdata_in;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [1:0] cmd_codec_id = '0;
  logic play_valid = 1'b0, play_ready;
  logic [19:0] play_left = '0, play_right = '0;
  logic rec_valid, rd_valid;
  logic [19:0] rec_left, rec_right;
  logic [15:0] rd_data, rx_tag;
  logic [9:0] rx_slot_req;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 bit_clk = ~bit_clk;

  aclink_engine u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_codec_id(cmd_codec_id), .play_valid(play_valid),
    .play_ready(play_ready), .play_left(play_left), .play_right(play_right),
    .rec_valid(rec_valid), .rec_left(rec_left), .rec_right(rec_right), .rd_valid(rd_valid),
    .rd_data(rd_data), .rx_tag(rx_tag), .rx_slot_req(rx_slot_req)
  );

  // Monitor on the falling edge: rebuilds outgoing frames and records pulses.
  logic [255:0] cur_out = '0, last_out = '0;
  int frame_cnt = 0, mpos = 0, since = 0, hi_run = 0, last_hi = 0, last_period = 0;
  bit mprev = 0, mseen = 0;
  int rec_cnt = 0, rd_cnt = 0;
  logic [19:0] got_l = '0, got_r = '0;
  logic [15:0] got_rd = '0;

  always @(negedge bit_clk) begin
    if (rst_n) begin
      if (sync && !mprev) begin
        mpos = 0; last_period = since; since = 1; mseen = 1;
      end else begin
        mpos = mpos + 1; since = since + 1;
      end
      if (sync) hi_run = hi_run + 1;
      else if (mprev) begin last_hi = hi_run; hi_run = 0; end
      mprev = sync;
      if (mseen && mpos < 256) begin
        cur_out[255-mpos] = sdata_out;
        if (mpos == 255) begin last_out = cur_out; frame_cnt = frame_cnt + 1; end
      end
      if (rec_valid) begin rec_cnt = rec_cnt + 1; got_l = rec_left; got_r = rec_right; end
      if (rd_valid) begin rd_cnt = rd_cnt + 1; got_rd = rd_data; end
    end
  end

  // Codec model: launches each incoming bit just after the rising edge.
  logic [255:0] next_in = '0, cur_in = '0;
  int cpos = 0;
  bit cprev = 0, cseen = 0;
  initial sdata_in = 1'b0;
  always @(posedge bit_clk) begin
    #1;
    if (sync && !cprev) begin cpos = 0; cseen = 1; cur_in = next_in; end
    else cpos = cpos + 1;
    cprev = sync;
    sdata_in = (cseen && cpos < 256) ? cur_in[255-cpos] : 1'b0;
  end

  function automatic logic [255:0] mk_in(logic [15:0] t, logic [19:0] s1, logic [19:0] s2,
                                         logic [19:0] s3, logic [19:0] s4);
    return {t, s1, s2, s3, s4, 160'b0};
  endfunction

  function automatic logic [19:0] slot_of(logic [255:0] f, int n);
    return f[255-16-20*(n-1) -: 20];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int t = frame_cnt;
    wait (frame_cnt == t + n);
  endtask

  task automatic send_play(input logic [19:0] l, input logic [19:0] r, output int acc);
    @(negedge bit_clk);
    play_valid = 1'b1; play_left = l; play_right = r;
    while (!play_ready) @(negedge bit_clk);
    @(posedge bit_clk);
    acc = frame_cnt;
    @(negedge bit_clk);
    play_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic wr, input logic [6:0] a, input logic [15:0] d,
                          input logic [1:0] id, output int acc);
    @(negedge bit_clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_codec_id = id;
    while (!cmd_ready) @(negedge bit_clk);
    @(posedge bit_clk);
    acc = frame_cnt;
    @(negedge bit_clk);
    cmd_valid = 1'b0;
  endtask

  // {play_left, play_right, rec_left, rec_right, record tags set}
  localparam logic [80:0] VEC [4] = '{
    {20'h12345, 20'hABCDE, 20'h0F0F0, 20'hF0F0F, 1'b1},
    {20'h80000, 20'h00001, 20'h55555, 20'hAAAAA, 1'b1},
    {20'hFFFFF, 20'h00000, 20'h13579, 20'h2468A, 1'b0},
    {20'h7FFFF, 20'hFFFFF, 20'h00001, 20'h80000, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge bit_clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc;
    int rc;
    logic [255:0] f;
    // R10: reset state
    repeat (3) @(negedge bit_clk);
    chk("R10 sync", sync, 0);
    chk("R10 sdata_out", sdata_out, 0);
    chk("R10 cmd_ready", cmd_ready, 1);
    chk("R10 play_ready", play_ready, 1);
    chk("R10 rd_valid", rd_valid, 0);
    chk("R10 rec_valid", rec_valid, 0);
    rst_n = 1'b1;

    wait_frames(3);
    chk("R1 sync high width", last_hi, 16);
    chk("R1 frame period", last_period, 256);
    chk("R6 idle frame all zero", last_out, 0);

    // R5, R7: table of playback and record vectors
    foreach (VEC[i]) begin
      logic [19:0] pl, pr, rl, rr;
      logic rv;
      {pl, pr, rl, rr, rv} = VEC[i];
      next_in = mk_in(rv ? 16'h9800 : 16'h8000, 20'h0, 20'h0, rl, rr);
      send_play(pl, pr, acc);
      wait (frame_cnt == acc + 2);
      f = last_out;
      chk("R2 play tag", f[255:240], 16'h9800);
      chk("R5 left slot", slot_of(f, 3), pl);
      chk("R5 right slot", slot_of(f, 4), pr);
      chk("R6 cmd slots zero", {slot_of(f, 1), slot_of(f, 2)}, 0);
      chk("R6 upper slots zero", f[159:0], 0);
      wait (frame_cnt == acc + 3);
      chk("R5 next frame tag clear", last_out[255:240], 0);
      chk("R5 next frame pcm zero", {slot_of(last_out, 3), slot_of(last_out, 4)}, 0);
      rc = rec_cnt;
      wait (frame_cnt == acc + 4);
      chk("R7 record pulse count", rec_cnt - rc, rv);
      if (rv) begin
        chk("R7 record left", got_l, rl);
        chk("R7 record right", got_r, rr);
      end
    end
    next_in = '0;

    // R2, R3, R4: register write
    send_cmd(1'b1, 7'h02, 16'h1234, 2'b01, acc);
    wait (frame_cnt == acc + 2);
    f = last_out;
    chk("R2 write tag with codec id", f[255:240], 16'hE001);
    chk("R3 write slot1", slot_of(f, 1), 20'h02000);
    chk("R3 write slot2", slot_of(f, 2), 20'h12340);
    chk("R4 ready after write", cmd_ready, 1);

    // R4: register read goes out with no data slot and blocks further commands
    send_cmd(1'b0, 7'h7C, 16'hFFFF, 2'b00, acc);
    wait (frame_cnt == acc + 2);
    f = last_out;
    chk("R4 read tag", f[255:240], 16'hC000);
    chk("R3 read slot1", slot_of(f, 1), 20'hFC000);
    chk("R4 read slot2 zero", slot_of(f, 2), 0);
    chk("R4 ready low while read open", cmd_ready, 0);

    // R8: slot 1 tag clear, matching address: request field seen, reply ignored
    next_in = mk_in(16'h8000, {1'b0, 7'h7C, 10'h2A5, 2'b00}, {16'hBEEF, 4'h0}, 20'h0, 20'h0);
    wait_frames(3);
    chk("R8 rx_tag", rx_tag, 16'h8000);
    chk("R8 slot request", rx_slot_req, 10'h2A5);
    chk("R9 untagged reply ignored", rd_cnt, 0);

    // R9: address mismatch ignored
    next_in = mk_in(16'hE000, {1'b0, 7'h10, 12'h0}, {16'h1111, 4'h0}, 20'h0, 20'h0);
    wait_frames(3);
    chk("R9 mismatch ignored", rd_cnt, 0);
    chk("R8 slot request cleared", rx_slot_req, 0);

    // R9: global flag clear ignored
    next_in = mk_in(16'h6000, {1'b0, 7'h7C, 12'h0}, {16'h2222, 4'h0}, 20'h0, 20'h0);
    wait_frames(3);
    chk("R9 not-ready reply ignored", rd_cnt, 0);
    chk("R9 read still open", cmd_ready, 0);

    // R9: matching reply completes the read once
    next_in = mk_in(16'hE000, {1'b0, 7'h7C, 12'h0}, {16'hBEEF, 4'h0}, 20'h0, 20'h0);
    wait_frames(3);
    chk("R9 reply count", rd_cnt, 1);
    chk("R9 reply data", got_rd, 16'hBEEF);
    chk("R9 ready restored", cmd_ready, 1);
    wait_frames(2);
    chk("R9 no repeat reply", rd_cnt, 1);

    // R7, R8: record tags set but global flag clear
    rc = rec_cnt;
    next_in = mk_in(16'h1800, 20'h0, 20'h0, 20'h11111, 20'h22222);
    wait_frames(3);
    chk("R7 not-ready record ignored", rec_cnt - rc, 0);
    chk("R8 rx_tag without global flag", rx_tag, 16'h1800);
    next_in = '0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule